// File: doc/BRIEF.md
# Packet Register-Write Conflict Detector

This block watches the general-purpose register writes that the instructions of one VLIW packet issue. It flags an exception when the same register is the destination more than once inside a packet. A scoreboard holds one bit per register. A packet-start strobe clears the scoreboard. Every checked write then sets the bit of its destination, and a write that finds its bit already set is a conflict.

Up to four write ports can be active in a cycle. Each port carries a valid bit, a register number, a pair flag and a skip flag. A pair flag makes the port cover register n and then register n+1. A skip flag marks a predicated write that did not execute. Ports are checked in ascending order, so a duplicate among ports in the same cycle is caught. A mode input selects one of two reporting conventions. In user mode the block reports the conflict cause code directly. In system mode it loads that code into a cause register and reports a precise-exception event code instead.

Top module: `pkt_wr_conflict_det`

## Requirements
- R1: `written_map` bit i is 1 exactly when register i (0 to 31) has been written by a checked write since the last packet start. The new bit is visible on the cycle after the clock edge that takes the write.
- R2: A cycle with `pkt_start` high first clears every flag. Writes in that same cycle are checked against the cleared map, so a register written in the previous packet can be written again without a conflict.
- R3: A write to register number 32 or above sets no flag and never raises a conflict.
- R4: A write to a register whose flag is clear sets the flag and raises nothing. A write to a register whose flag is set is a conflict.
- R5: A pair write to n is two single checks, first n and then n+1. A pair at 31 checks only 31, because 32 is out of range.
- R6: A write with its skip flag high is neither checked nor recorded, whether it is a single or a pair write.
- R7: Ports valid in the same cycle are checked in ascending port order, each against the flags left by the lower ports. A duplicate among them, including overlap with a pair, is a conflict.
- R8: In user mode (`sys_mode` = 0), the reported code is 0x1D and `cause_reg` keeps its value. `exc_code` is 0x00 whenever `exc_pulse` is low.
- R9: In system mode (`sys_mode` = 1), the reported code is event 0x02 and `cause_reg` is loaded with 0x1D. The mode is sampled in the cycle of the conflicting write.
- R10: `exc_pulse` is high for one cycle, on the cycle after the first conflict of a packet. Later conflicts in the same packet raise nothing until the next `pkt_start`.
- R11: A synchronous active-high `rst` clears the map, `cause_reg`, `exc_pulse` and `exc_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_start | input | 1 | First cycle of a new packet; clears the scoreboard |
| sys_mode | input | 1 | 0 = user reporting, 1 = system reporting |
| wr_valid | input | NUM_PORTS | Per-port write valid |
| wr_reg | input | NUM_PORTS*IDX_W | Per-port destination register number, port p at bits [p*IDX_W +: IDX_W] |
| wr_pair | input | NUM_PORTS | Per-port register-pair flag |
| wr_skip | input | NUM_PORTS | Per-port predicated-skip flag |
| exc_pulse | output | 1 | One-cycle conflict exception strobe |
| exc_code | output | 8 | 0x1D (user) or 0x02 (system) with the strobe, else 0x00 |
| cause_reg | output | 8 | Cause register, loaded with 0x1D on a system-mode report |
| written_map | output | NUM_REGS | Current written-register bitmap |

## Verification
The bench goes after three corner groups: the range edge, pair wrap at the top, and same-cycle duplicates. For the range edge it sweeps every 6-bit register number. A detector that wraps or truncates register 32 and above onto the low registers would raise false conflicts there. For pair wrap it tries every pair base. A design that lets the pair at 31 touch bit 0, or wraps 63+1 to 0, would set a wrong flag. For same-cycle duplicates it tries every ordered pair of ports. A design that checks each port only against the registered map would miss these.

Skip suppression, the single-pulse rule after repeated conflicts, and the mode-dependent codes and cause register are each checked directly. A long stretch of pseudo-random traffic is then compared every cycle against an arithmetic model of the requirements.

// File: rtl/pwc_pkg.sv
package pwc_pkg;
   localparam int unsigned CODE_W = 8;
   localparam logic [CODE_W-1:0] CAUSE_WR_CONFLICT = 8'h1D;
   localparam logic [CODE_W-1:0] EVT_PRECISE       = 8'h02;
   localparam logic [CODE_W-1:0] CODE_NONE         = 8'h00;

   typedef enum logic {
      RPT_USER   = 1'b0,
      RPT_SYSTEM = 1'b1
   } rpt_mode_e;

   typedef struct packed {
      logic valid;
      logic pair;
      logic skip;
   } wr_ctl_t;
endpackage

// File: rtl/pwc_slot_check.sv
module pwc_slot_check #(
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned IW       = 7
) (
   input  logic                en,
   input  logic [IW-1:0]       idx,
   input  logic [NUM_REGS-1:0] acc_in,
   output logic [NUM_REGS-1:0] acc_out,
   output logic                hit
);
   localparam int unsigned SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

   if (IW < SEL_W) begin : g_bad_iw
      $error("pwc_slot_check: index width too small for register count");
   end

   logic                in_range;
   logic [SEL_W-1:0]    sel;
   logic [NUM_REGS-1:0] onehot;
   logic                active;

   always_comb begin
      in_range = (int'(idx) < int'(NUM_REGS));
      sel      = idx[SEL_W-1:0];
      onehot   = {{(NUM_REGS-1){1'b0}}, 1'b1} << sel;
      active   = en & in_range;
      hit      = active & (|(acc_in & onehot));
      acc_out  = active ? (acc_in | onehot) : acc_in;
   end
endmodule

// File: rtl/pwc_port_stage.sv
module pwc_port_stage #(
   parameter int unsigned NUM_REGS     = 32,
   parameter int unsigned IDX_W        = 6,
   parameter bit          PAIR_SUPPORT = 1'b1
) (
   input  pwc_pkg::wr_ctl_t    ctl,
   input  logic [IDX_W-1:0]    reg_idx,
   input  logic [NUM_REGS-1:0] acc_in,
   output logic [NUM_REGS-1:0] acc_out,
   output logic                hit
);
   localparam int unsigned IW = IDX_W + 1;

   logic                en;
   logic [IW-1:0]       idx_lo;
   logic [NUM_REGS-1:0] acc_mid;
   logic                hit_lo;

   always_comb begin
      en     = ctl.valid & ~ctl.skip;
      idx_lo = {1'b0, reg_idx};
   end

   pwc_slot_check #(.NUM_REGS(NUM_REGS), .IW(IW)) u_lo (
      .en      (en),
      .idx     (idx_lo),
      .acc_in  (acc_in),
      .acc_out (acc_mid),
      .hit     (hit_lo)
   );

   if (PAIR_SUPPORT) begin : g_pair
      logic [IW-1:0] idx_hi;
      logic          hit_hi;
      logic          en_hi;

      always_comb begin
         idx_hi = idx_lo + IW'(1);
         en_hi  = en & ctl.pair;
      end

      pwc_slot_check #(.NUM_REGS(NUM_REGS), .IW(IW)) u_hi (
         .en      (en_hi),
         .idx     (idx_hi),
         .acc_in  (acc_mid),
         .acc_out (acc_out),
         .hit     (hit_hi)
      );

      assign hit = hit_lo | hit_hi;
   end else begin : g_single
      assign acc_out = acc_mid;
      assign hit     = hit_lo;
   end
endmodule

// File: rtl/pwc_report.sv
module pwc_report (
   input  logic       clk,
   input  logic       rst,
   input  logic       pkt_start,
   input  logic       conflict,
   input  logic       sys_mode,
   output logic       exc_pulse,
   output logic [7:0] exc_code,
   output logic [7:0] cause_reg
);
   import pwc_pkg::*;

   logic      reported_q;
   logic      reported_base;
   logic      fire;
   rpt_mode_e mode;

   always_comb begin
      mode          = rpt_mode_e'(sys_mode);
      reported_base = pkt_start ? 1'b0 : reported_q;
      fire          = conflict & ~reported_base;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         reported_q <= 1'b0;
         exc_pulse  <= 1'b0;
         exc_code   <= CODE_NONE;
         cause_reg  <= CODE_NONE;
      end else begin
         reported_q <= reported_base | conflict;
         exc_pulse  <= fire;
         if (!fire) begin
            exc_code <= CODE_NONE;
         end else if (mode == RPT_SYSTEM) begin
            exc_code  <= EVT_PRECISE;
            cause_reg <= CAUSE_WR_CONFLICT;
         end else begin
            exc_code <= CAUSE_WR_CONFLICT;
         end
      end
   end
endmodule

// File: rtl/pkt_wr_conflict_det.sv
module pkt_wr_conflict_det #(
   parameter int unsigned NUM_REGS     = 32,
   parameter int unsigned IDX_W        = 6,
   parameter int unsigned NUM_PORTS    = 4,
   parameter bit          PAIR_SUPPORT = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       pkt_start,
   input  logic                       sys_mode,
   input  logic [NUM_PORTS-1:0]       wr_valid,
   input  logic [NUM_PORTS*IDX_W-1:0] wr_reg,
   input  logic [NUM_PORTS-1:0]       wr_pair,
   input  logic [NUM_PORTS-1:0]       wr_skip,
   output logic                       exc_pulse,
   output logic [7:0]                 exc_code,
   output logic [7:0]                 cause_reg,
   output logic [NUM_REGS-1:0]        written_map
);
   import pwc_pkg::*;

   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("pkt_wr_conflict_det: NUM_PORTS must be at least 1");
   end
   if (NUM_REGS < 2) begin : g_bad_regs
      $error("pkt_wr_conflict_det: NUM_REGS must be at least 2");
   end
   if ((1 << IDX_W) < NUM_REGS) begin : g_bad_idx
      $error("pkt_wr_conflict_det: IDX_W cannot address every register");
   end

   logic [NUM_REGS-1:0]  map_q;
   logic [NUM_REGS-1:0]  acc [NUM_PORTS+1];
   logic [NUM_PORTS-1:0] port_hit;
   logic                 conflict;

   assign acc[0] = pkt_start ? '0 : map_q;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      wr_ctl_t ctl;
      assign ctl = '{valid: wr_valid[p], pair: wr_pair[p], skip: wr_skip[p]};

      pwc_port_stage #(
         .NUM_REGS     (NUM_REGS),
         .IDX_W        (IDX_W),
         .PAIR_SUPPORT (PAIR_SUPPORT)
      ) u_stage (
         .ctl     (ctl),
         .reg_idx (wr_reg[p*IDX_W +: IDX_W]),
         .acc_in  (acc[p]),
         .acc_out (acc[p+1]),
         .hit     (port_hit[p])
      );
   end

   assign conflict = |port_hit;

   always_ff @(posedge clk) begin
      if (rst) begin
         map_q <= '0;
      end else begin
         map_q <= acc[NUM_PORTS];
      end
   end

   pwc_report u_report (
      .clk       (clk),
      .rst       (rst),
      .pkt_start (pkt_start),
      .conflict  (conflict),
      .sys_mode  (sys_mode),
      .exc_pulse (exc_pulse),
      .exc_code  (exc_code),
      .cause_reg (cause_reg)
   );

   assign written_map = map_q;
endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
   parameter int unsigned NUM_REGS  = 32,
   parameter int unsigned NUM_PORTS = 4
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 pkt_start,
   input logic                 sys_mode,
   input logic [NUM_PORTS-1:0] wr_valid,
   input logic                 exc_pulse,
   input logic [7:0]           exc_code,
   input logic [7:0]           cause_reg,
   input logic [NUM_REGS-1:0]  written_map
);
   AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (written_map == '0 && !exc_pulse && exc_code == 8'h00 && cause_reg == 8'h00)); // R11
   AST_MAP_ONLY_GROWS: assert property (@(posedge clk) disable iff (rst)
      !pkt_start |=> ((written_map & $past(written_map)) == $past(written_map))); // R1
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (pkt_start && wr_valid == '0) |=> (written_map == '0)); // R2
   AST_NO_WRITE_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
      (wr_valid == '0) |=> !exc_pulse); // R4
   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
      (exc_pulse && !pkt_start) |=> !exc_pulse); // R10
   AST_CODE_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !exc_pulse |-> (exc_code == 8'h00)); // R8
   AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
      exc_pulse |-> (exc_code == 8'h02 || exc_code == 8'h1D)); // R8
   AST_USER_CAUSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      !sys_mode |=> $stable(cause_reg)); // R8
   AST_SYS_CAUSE_LOADED: assert property (@(posedge clk) disable iff (rst)
      (exc_pulse && exc_code == 8'h02) |-> (cause_reg == 8'h1D)); // R9
endmodule

bind pkt_wr_conflict_det pwc_checker #(
   .NUM_REGS  (NUM_REGS),
   .NUM_PORTS (NUM_PORTS)
) u_pwc_checker (
   .clk         (clk),
   .rst         (rst),
   .pkt_start   (pkt_start),
   .sys_mode    (sys_mode),
   .wr_valid    (wr_valid),
   .exc_pulse   (exc_pulse),
   .exc_code    (exc_code),
   .cause_reg   (cause_reg),
   .written_map (written_map)
);

// File: tb/tb_pkt_wr_conflict_det.sv
module tb_pkt_wr_conflict_det;
   localparam int NR = 32;
   localparam int IW = 6;
   localparam int NP = 4;

   logic             clk = 1'b0;
   logic             rst;
   logic             pkt_start;
   logic             sys_mode;
   logic [NP-1:0]    wr_valid;
   logic [NP*IW-1:0] wr_reg;
   logic [NP-1:0]    wr_pair;
   logic [NP-1:0]    wr_skip;
   logic             exc_pulse;
   logic [7:0]       exc_code;
   logic [7:0]       cause_reg;
   logic [NR-1:0]    written_map;

   always #2.5 clk = ~clk;

   pkt_wr_conflict_det #(.NUM_REGS(NR), .IDX_W(IW), .NUM_PORTS(NP)) dut (
      .clk(clk), .rst(rst), .pkt_start(pkt_start), .sys_mode(sys_mode),
      .wr_valid(wr_valid), .wr_reg(wr_reg), .wr_pair(wr_pair), .wr_skip(wr_skip),
      .exc_pulse(exc_pulse), .exc_code(exc_code), .cause_reg(cause_reg),
      .written_map(written_map)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   logic [NR-1:0] m_map   = '0;
   logic          m_done  = 1'b0;
   logic [7:0]    m_cause = 8'h00;
   logic          e_pulse = 1'b0;
   logic [7:0]    e_code  = 8'h00;

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic idle();
      rst = 1'b0; pkt_start = 1'b0;
      wr_valid = '0; wr_reg = '0; wr_pair = '0; wr_skip = '0;
   endtask

   task automatic setp(int p, int r, bit pr, bit sk);
      wr_valid[p]        = 1'b1;
      wr_reg[p*IW +: IW] = r[IW-1:0];
      wr_pair[p]         = pr;
      wr_skip[p]         = sk;
   endtask

   // Arithmetic model of the requirements for the upcoming clock edge
   task automatic model();
      logic [NR-1:0] base;
      logic          confl;
      confl = 1'b0;
      if (rst) begin
         m_map = '0; m_done = 1'b0; m_cause = 8'h00; e_pulse = 1'b0; e_code = 8'h00;
         return;
      end
      base = pkt_start ? '0 : m_map;
      for (int p = 0; p < NP; p++) begin
         if (wr_valid[p] && !wr_skip[p]) begin
            for (int k = 0; k < 2; k++) begin
               int r;
               r = int'(wr_reg[p*IW +: IW]) + k;
               if ((k == 0 || wr_pair[p]) && r < NR) begin
                  if (base[r]) confl = 1'b1;
                  else base[r] = 1'b1;
               end
            end
         end
      end
      e_pulse = confl && !(pkt_start ? 1'b0 : m_done);
      m_done  = (pkt_start ? 1'b0 : m_done) | confl;
      e_code  = !e_pulse ? 8'h00 : (sys_mode ? 8'h02 : 8'h1D);
      if (e_pulse && sys_mode) m_cause = 8'h1D;
      m_map = base;
   endtask

   task automatic step(string tag);
      model();
      @(posedge clk);
      @(negedge clk);
      chk(tag, "written_map", 64'(written_map), 64'(m_map));
      chk(tag, "exc_pulse",   64'(exc_pulse),   64'(e_pulse));
      chk(tag, "exc_code",    64'(exc_code),    64'(e_code));
      chk(tag, "cause_reg",   64'(cause_reg),   64'(m_cause));
      idle();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      idle();
      sys_mode = 1'b0;
      @(negedge clk);
      // R11: reset state
      rst = 1'b1; step("R11");
      rst = 1'b1; step("R11");

      // R1 R3 R4: every register number, first write then repeat
      for (int r = 0; r < 64; r++) begin
         pkt_start = 1'b1; setp(0, r, 1'b0, 1'b0);
         step(r < NR ? "R1" : "R3");
         setp(r % NP, r, 1'b0, 1'b0);
         step(r < NR ? "R4" : "R3");
      end

      // R5: every pair base, then write the high half alone
      for (int n = 0; n < 64; n++) begin
         pkt_start = 1'b1; setp(1, n, 1'b1, 1'b0);
         step("R5");
         setp(2, (n + 1) % 64, 1'b0, 1'b0);
         step("R5");
      end

      // R6: skipped single and pair writes leave no trace
      for (int r = 0; r < NR; r++) begin
         pkt_start = 1'b1; setp(3, r, r[0], 1'b1);
         step("R6");
         setp(0, r, 1'b0, 1'b0);
         step("R6");
      end

      // R7: every ordered port pair writing one register in one cycle
      for (int a = 0; a < NP; a++) begin
         for (int b = 0; b < NP; b++) begin
            if (a != b) begin
               pkt_start = 1'b1; setp(a, 7, 1'b0, 1'b0); setp(b, 7, 1'b0, 1'b0);
               step("R7");
               pkt_start = 1'b1; setp(a, 6, 1'b1, 1'b0); setp(b, 7, 1'b0, 1'b0);
               step("R7");
            end
         end
      end
      pkt_start = 1'b1;
      setp(0, 1, 1'b0, 1'b0); setp(1, 2, 1'b1, 1'b0); setp(2, 9, 1'b0, 1'b0); setp(3, 30, 1'b1, 1'b0);
      step("R7");

      // R2: start clears; re-writing last packet's registers is legal
      pkt_start = 1'b1; step("R2");
      setp(0, 1, 1'b0, 1'b0); step("R2");
      pkt_start = 1'b1; setp(2, 1, 1'b0, 1'b0); step("R2");

      // R8: user mode reporting
      sys_mode = 1'b0;
      pkt_start = 1'b1; setp(0, 12, 1'b0, 1'b0); step("R8");
      setp(1, 12, 1'b0, 1'b0); step("R8");
      // R9: system mode reporting
      sys_mode = 1'b1;
      pkt_start = 1'b1; setp(0, 13, 1'b0, 1'b0); step("R9");
      setp(1, 13, 1'b0, 1'b0); step("R9");
      sys_mode = 1'b0;
      pkt_start = 1'b1; setp(0, 13, 1'b0, 1'b0); setp(1, 13, 1'b0, 1'b0); step("R8");

      // R10: repeated conflicts give one pulse per packet
      pkt_start = 1'b1; setp(0, 3, 1'b0, 1'b0); step("R10");
      for (int i = 0; i < 3; i++) begin
         setp(i, 3, 1'b0, 1'b0); step("R10");
      end
      pkt_start = 1'b1; setp(0, 3, 1'b0, 1'b0); setp(1, 3, 1'b0, 1'b0); step("R10");
      pkt_start = 1'b1; setp(0, 4, 1'b0, 1'b0); setp(1, 4, 1'b0, 1'b0); step("R10");
      step("R10");

      // R7: pseudo-random traffic against the model
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] rv;
         rv = $urandom;
         pkt_start = (rv[1:0] == 2'b00);
         sys_mode  = rv[2];
         for (int p = 0; p < NP; p++) begin
            logic [31:0] pv;
            pv = $urandom;
            if (pv[0]) setp(p, (pv[3] ? int'(pv[9:4]) : int'(pv[6:4]) + 28), pv[1], pv[2] & pv[10]);
         end
         if (rv[9:3] == 7'd0) rst = 1'b1;
         step("R7");
      end

      // R11: reset after a system report clears the cause register
      sys_mode = 1'b1;
      pkt_start = 1'b1; setp(0, 5, 1'b0, 1'b0); setp(1, 5, 1'b0, 1'b0); step("R9");
      rst = 1'b1; step("R11");
      step("R11");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule